// File: doc/BRIEF.md
# Chopped Conversion Timing Sequencer

This block generates the timing skeleton for a chopped sigma-delta converter front end. It divides the master clock into modulator cycles. It runs a chop phase that flips once per output word and drives a complementary pair of excitation lines. After every chop edge it holds the modulator in reset for a programmable number of modulator cycles. It then lets the decimation filter take samples long enough to settle fully before it flags one output word. The modulator and the filter arithmetic sit outside the block. The block only tells them when to reset, when to take a sample and when a result is due.

With chopping on, one output period covers the settling delay plus three filter-settling intervals of SF modulator cycles each. With chopping off, the period is SF modulator cycles and no delay is used. AC excitation drives the excitation pair from the chop phase. It takes effect only while chopping is on and no internal calibration is in progress. All pins are plain control and status lines. No data words cross the block, so it has no valid/ready interface and no back-pressure.

Top module: `chop_seq_top`

## Requirements
- R1: A modulator cycle is 16 master clocks. `filt_take` is never high for two clocks in a row. While the filter runs, it pulses exactly once per modulator cycle.
- R2: With `chop_en`=1, consecutive `word_rdy` pulses are 16·(D + 3·SF) clocks apart, where D is `dly_code` and SF is `sf`. Between them `filt_take` pulses exactly 3·SF times.
- R3: With `chop_en`=1, `mod_rst` is high for 16·D clocks in each output period, at the start of the phase. `filt_take` is never high while `mod_rst` is high.
- R4: With `chop_en`=1, `chop_ph` inverts at the clock edge that ends each `word_rdy` cycle, and changes at no other time except a restart.
- R5: With `chop_en`=0, `word_rdy` pulses every 16·SF clocks with SF `filt_take` pulses between them. `mod_rst` stays low, `chop_ph` stays 0, and `dly_code` has no effect.
- R6: `exc_n` is always the inverse of `exc_p`. `exc_p` changes only at a modulator-cycle boundary or at a restart.
- R7: When `chop_en`=1, `ac_en`=1 and `cal_busy`=0, `exc_p` equals `chop_ph`. Otherwise `exc_p` is 1.
- R8: With `chop_en`=0, `ac_en` has no effect: `exc_p` stays 1.
- R9: With `cal_busy`=1, AC excitation is treated as off, so `exc_p` is 1 even with `chop_en`=1 and `ac_en`=1.
- R10: A change of `chop_en`, `sf`, or (with chopping on) `dly_code` restarts the sequence and discards the word in progress. The first `word_rdy` appears in the 16·N-th clock cycle after the first edge that sees the new settings, with `chop_ph`=0 in that cycle. N is D + 3·SF when chopped and SF when not.
- R11: During reset `chop_ph`=0, `mod_rst`=0, `filt_take`=0, `word_rdy`=0, `exc_p`=1 and `exc_n`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chop_en | input | 1 | Chopping enable |
| ac_en | input | 1 | AC excitation enable |
| cal_busy | input | 1 | Internal calibration in progress |
| dly_code | input | 4 | Settling delay after each chop edge, in modulator cycles |
| sf | input | 12 | Decimation factor in modulator cycles, 1 or more |
| chop_ph | output | 1 | Current chop phase |
| exc_p | output | 1 | Excitation line, true polarity |
| exc_n | output | 1 | Excitation line, inverse polarity |
| mod_rst | output | 1 | Holds the modulator in reset during the settling delay |
| filt_take | output | 1 | One-clock strobe: the filter takes a sample |
| word_rdy | output | 1 | One-clock pulse: an output word is complete |

## Verification
The assertions assume that `sf` is never zero and that inputs change only between clock edges. A `cal_busy` change without a restart may alter `exc_p` only at the next modulator boundary. The stimulus meets these assumptions. Every `sf` it applies is between 1 and 5. It drives all inputs just after a falling edge. Each new setting changes `sf` or `chop_en`, so every step is a real restart whose first-word latency is predictable.

// File: rtl/chop_seq_pkg.sv
package chop_seq_pkg;
  typedef enum logic {
    PH_RUN   = 1'b0,
    PH_DELAY = 1'b1
  } phase_e;
endpackage

// File: rtl/chop_mod_prescaler.sv
module chop_mod_prescaler #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (restart)  cnt <= '0;
    else if (tick)     cnt <= '0;
    else               cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/chop_phase_seq.sv
module chop_phase_seq
  import chop_seq_pkg::*;
#(
  parameter int DLY_W = 4,
  parameter int SF_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             tick,
  input  logic             chop_en,
  input  logic [DLY_W-1:0] dly_code,
  input  logic [SF_W-1:0]  sf,
  output logic             chop_ph,
  output logic             in_delay,
  output logic             take,
  output logic             last
);
  localparam int CNT_W = SF_W + 2;

  phase_e           state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] sf_x;
  logic [CNT_W-1:0] run_len;
  logic [CNT_W-1:0] dly_last;
  logic             dly_nz;
  phase_e           start_state;

  assign sf_x        = CNT_W'(sf);
  assign run_len     = chop_en ? (sf_x + (sf_x << 1)) : sf_x;
  assign dly_last    = CNT_W'(dly_code) - CNT_W'(1);
  assign dly_nz      = (dly_code != '0);
  assign start_state = (chop_en && dly_nz) ? PH_DELAY : PH_RUN;

  assign in_delay = (state == PH_DELAY);
  assign take     = tick && (state == PH_RUN);
  assign last     = take && (cnt == run_len - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= PH_RUN;
      cnt     <= '0;
      chop_ph <= 1'b0;
    end else if (restart) begin
      state   <= start_state;
      cnt     <= '0;
      chop_ph <= 1'b0;
    end else if (tick) begin
      case (state)
        PH_DELAY: begin
          if (cnt == dly_last) begin
            state <= PH_RUN;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: begin
          if (last) begin
            cnt <= '0;
            if (chop_en) begin
              chop_ph <= ~chop_ph;
              if (dly_nz) state <= PH_DELAY;
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/chop_exc_driver.sv
module chop_exc_driver (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic tick,
  input  logic chop_en,
  input  logic ac_en,
  input  logic cal_busy,
  input  logic chop_ph,
  output logic exc_p,
  output logic exc_n
);
  logic ac_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              ac_q <= 1'b0;
    else if (restart || tick) ac_q <= chop_en && ac_en && !cal_busy;
  end

  assign exc_p = ac_q ? chop_ph : 1'b1;
  assign exc_n = ~exc_p;
endmodule

// File: rtl/chop_seq_top.sv
module chop_seq_top #(
  parameter int MOD_DIV = 16,
  parameter int DLY_W   = 4,
  parameter int SF_W    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chop_en,
  input  logic             ac_en,
  input  logic             cal_busy,
  input  logic [DLY_W-1:0] dly_code,
  input  logic [SF_W-1:0]  sf,
  output logic             chop_ph,
  output logic             exc_p,
  output logic             exc_n,
  output logic             mod_rst,
  output logic             filt_take,
  output logic             word_rdy
);
  localparam int KEY_W = 1 + DLY_W + SF_W;

  logic [KEY_W-1:0] key, key_q;
  logic             restart;
  logic             mod_tick;

  assign key     = {chop_en, (chop_en ? dly_code : {DLY_W{1'b0}}), sf};
  assign restart = (key != key_q);

  always_ff @(posedge clk) begin
    if (!rst_n) key_q <= '0;
    else        key_q <= key;
  end

  chop_mod_prescaler #(.DIV(MOD_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(mod_tick)
  );

  chop_phase_seq #(.DLY_W(DLY_W), .SF_W(SF_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(mod_tick),
    .chop_en(chop_en), .dly_code(dly_code), .sf(sf),
    .chop_ph(chop_ph), .in_delay(mod_rst), .take(filt_take), .last(word_rdy)
  );

  chop_exc_driver u_exc (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(mod_tick),
    .chop_en(chop_en), .ac_en(ac_en), .cal_busy(cal_busy),
    .chop_ph(chop_ph), .exc_p(exc_p), .exc_n(exc_n)
  );
endmodule

// File: rtl/chop_seq_checker.sv
module chop_seq_checker (
  input logic clk,
  input logic rst_n,
  input logic chop_en,
  input logic restart,
  input logic tick,
  input logic chop_ph,
  input logic exc_p,
  input logic exc_n,
  input logic mod_rst,
  input logic filt_take,
  input logic word_rdy
);
  p_take_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    filt_take |-> tick);
  p_take_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    filt_take |=> !filt_take);
  p_word_on_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    word_rdy |-> filt_take);
  p_no_take_in_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mod_rst |-> !filt_take);
  p_phase_at_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(chop_ph) && !$past(restart)) |-> $past(word_rdy));
  p_unchopped_no_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!chop_en && $past(!chop_en)) |-> !mod_rst);
  p_exc_compl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_p != exc_n);
  p_exc_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(exc_p) |-> $past(tick || restart));
  p_ac_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!chop_en && $past(!chop_en)) |-> exc_p);
endmodule

bind chop_seq_top chop_seq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .chop_en(chop_en), .restart(restart),
  .tick(mod_tick), .chop_ph(chop_ph), .exc_p(exc_p), .exc_n(exc_n),
  .mod_rst(mod_rst), .filt_take(filt_take), .word_rdy(word_rdy)
);

// File: tb/chop_seq_top_test.sv
module chop_seq_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chop_en = 1'b0, ac_en = 1'b0, cal_busy = 1'b0;
  logic [3:0]  dly_code = '0;
  logic [11:0] sf = 12'd1;
  logic        chop_ph, exc_p, exc_n, mod_rst, filt_take, word_rdy;

  always #10 clk = ~clk;

  chop_seq_top uut (
    .clk(clk), .rst_n(rst_n), .chop_en(chop_en), .ac_en(ac_en),
    .cal_busy(cal_busy), .dly_code(dly_code), .sf(sf),
    .chop_ph(chop_ph), .exc_p(exc_p), .exc_n(exc_n), .mod_rst(mod_rst),
    .filt_take(filt_take), .word_rdy(word_rdy)
  );

  typedef struct {
    int unsigned ivl;
    int unsigned nrst;
    int unsigned ntake;
    bit          ph;
    bit          exc;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  int unsigned errors = 0, checks = 0;
  int unsigned t = 0, t_last = 0, nrst = 0, ntake = 0;
  bit          restart_pending = 1'b0;
  bit          timed_out = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Monitor: compares each completed word against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n) begin
      t++;
      if (t > 150000 && !timed_out) begin
        timed_out = 1'b1;
        chk(1'b0, "watchdog", int'(t), 150000);
      end
      if (restart_pending) begin
        t_last = t - 1;
        nrst = 0;
        ntake = 0;
        restart_pending = 1'b0;
      end
      if (mod_rst) nrst++;
      if (filt_take) ntake++;
      chk(exc_n == ~exc_p, "R6 exc_n inverse", int'(exc_n), int'(~exc_p));
      if (word_rdy) begin
        if (exp_q.size() != 0) begin
          exp_t e;
          e = exp_q.pop_front();
          chk(t - t_last == e.ivl, {e.tag, " word interval (R2/R5/R10)"}, int'(t - t_last), int'(e.ivl));
          chk(nrst == e.nrst, {e.tag, " mod_rst clocks R3"}, int'(nrst), int'(e.nrst));
          chk(ntake == e.ntake, {e.tag, " filt_take count R1"}, int'(ntake), int'(e.ntake));
          chk(chop_ph == e.ph, {e.tag, " chop phase R4"}, int'(chop_ph), int'(e.ph));
          chk(exc_p == e.exc, {e.tag, " exc_p R7"}, int'(exc_p), int'(e.exc));
        end
        t_last = t;
        nrst = 0;
        ntake = 0;
      end
    end
  end

  task automatic run_cfg(input bit c, input bit a, input bit cb, input int d,
                         input int s, input int nwords, input string tag);
    int unsigned n;
    bit          ac_eff;
    @(negedge clk);
    #1;
    chop_en  = c;
    ac_en    = a;
    cal_busy = cb;
    dly_code = 4'(d);
    sf       = 12'(s);
    if (rst_n) restart_pending = 1'b1;
    n      = c ? (d + 3 * s) : s;
    ac_eff = c && a && !cb;
    for (int i = 0; i < nwords; i++) begin
      exp_t e;
      e.ivl   = 16 * n;
      e.nrst  = c ? 16 * d : 0;
      e.ntake = c ? 3 * s : s;
      e.ph    = c ? bit'(i % 2) : 1'b0;
      e.exc   = ac_eff ? e.ph : 1'b1;
      e.tag   = tag;
      exp_q.push_back(e);
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0 && !timed_out) @(negedge clk);
  endtask

  initial begin
    // R11: reset state
    run_cfg(1'b1, 1'b1, 1'b0, 3, 2, 4, "R2 R7 chop ac dl3 sf2");
    repeat (3) @(negedge clk);
    chk(chop_ph == 1'b0, "R11 chop_ph in reset", int'(chop_ph), 0);
    chk(mod_rst == 1'b0, "R11 mod_rst in reset", int'(mod_rst), 0);
    chk(filt_take == 1'b0, "R11 filt_take in reset", int'(filt_take), 0);
    chk(word_rdy == 1'b0, "R11 word_rdy in reset", int'(word_rdy), 0);
    chk(exc_p == 1'b1 && exc_n == 1'b0, "R11 exc pair in reset", int'({exc_p, exc_n}), 2);
    #1;
    rst_n = 1'b1;
    restart_pending = 1'b1;
    drain();
    // chop with no delay, dc excitation
    run_cfg(1'b1, 1'b0, 1'b0, 0, 3, 3, "R3 R10 chop dl0 sf3");
    drain();
    // R5 R8: no chop, delay code and ac ignored
    run_cfg(1'b0, 1'b1, 1'b0, 7, 5, 3, "R5 R8 nochop dl7 sf5");
    drain();
    // R9: calibration forces dc excitation, maximum delay
    run_cfg(1'b1, 1'b1, 1'b1, 15, 1, 3, "R9 cal dl15 sf1");
    drain();
    // R10: restart mid-word into a fresh phase
    run_cfg(1'b1, 1'b1, 1'b0, 2, 4, 1, "R10 pre");
    repeat (100) @(negedge clk);
    exp_q.delete();
    run_cfg(1'b1, 1'b1, 1'b0, 2, 5, 2, "R10 restart dl2 sf5");
    drain();
    chk(checks > 40, "R1 check coverage", int'(checks), 41);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule